// File: doc/BRIEF.md
# Packed Arithmetic Right Shifter

This block applies one arithmetic right shift to every lane of a packed vector. The lanes can be 16 or 32 bits wide, and the vector can be 64 or 128 bits wide. A single count operand sets the shift for all lanes. The count is read as an unsigned 64-bit quantity.

If the count is greater than or equal to the lane width, every lane saturates to copies of its own sign bit. If the whole 64-bit count is zero, the result goes out without a write-enable, so the destination register keeps its old contents.

The unit registers its result one cycle after a valid strobe. It sits between operand fetch and register-file writeback in a vector execution pipe.

Top module: `vec_sar_unit`

## Requirements
- R1: While `rst_n` is low, `res_wen` is 0 and `res_vec` is all zeros.
- R2: A strobe on `in_valid` updates `res_vec` on the next rising edge. A cycle without `in_valid` drives `res_wen` to 0 on the next edge and leaves `res_vec` unchanged.
- R3: When bits 63:0 of `cnt_opnd` are all zero, `res_wen` is 0 in the cycle after the strobe. `res_vec` then carries the source unchanged, apart from the narrow-form masking of R10.
- R4: With `lane_sel`=0 (16-bit lanes) and a count from 1 to 15, each lane becomes its signed value shifted right by the count. The vacated upper bits are filled with the lane's sign. `res_wen` is 1.
- R5: With `lane_sel`=0 and a count above 15, each 16-bit lane becomes 16'hFFFF if its bit 15 was 1, and 0 otherwise.
- R6: With `lane_sel`=1 (32-bit lanes) and a count from 1 to 31, each lane becomes its signed value shifted right by the count.
- R7: With `lane_sel`=1 and a count above 31, each 32-bit lane becomes all ones if its bit 31 was 1, and 0 otherwise.
- R8: The range test uses the full 64-bit count. A count whose low byte is small but which has higher bits set, such as 64'h1_0000_0003, saturates.
- R9: Bits 127:64 of `cnt_opnd` have no effect on `res_vec` or `res_wen`.
- R10: With `wide_sel`=0 (64-bit vector), only `src_vec[63:0]` is shifted, giving four 16-bit lanes or two 32-bit lanes. `res_vec[127:64]` is 0. With `wide_sel`=1, all 128 bits are shifted, giving eight or four lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| lane_sel | input | 1 | 0 selects 16-bit lanes, 1 selects 32-bit lanes |
| wide_sel | input | 1 | 0 selects a 64-bit vector, 1 selects a 128-bit vector |
| src_vec | input | 128 | Packed source operand |
| cnt_opnd | input | 128 | Count operand; only bits 63:0 are examined |
| res_vec | output | 128 | Registered shifted vector |
| res_wen | output | 1 | Registered destination write-enable |

## Verification
The assertions assume that `in_valid`, the mode selects and both operands are stable and known at each rising edge while reset is released. They also assume that reset is asserted from time zero, so the registers hold known values before the first edge.

The bench drives every input on the falling edge, so the values are settled well before the edge that samples them. Its counts fall into four equally likely classes: all zero, in range, wider than the lane, and zero in the low half with noise in the upper half. Together these keep every assertion's antecedent exercised.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned LANE16_W = 16;
  localparam int unsigned LANE32_W = 32;
  localparam int unsigned SH16_W   = $clog2(LANE16_W);
  localparam int unsigned SH32_W   = $clog2(LANE32_W);
  typedef enum logic {LANE_HALF = 1'b0, LANE_WORD = 1'b1} lane_e;
endpackage

// File: rtl/sar_count_dec.sv
module sar_count_dec
  import sar_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic [CNT_W-1:0]  cnt,
  output logic              cnt_nz,
  output logic [SH16_W-1:0] amt16,
  output logic [SH32_W-1:0] amt32
);
  localparam logic [CNT_W-1:0] MAX16 = CNT_W'(LANE16_W - 1);
  localparam logic [CNT_W-1:0] MAX32 = CNT_W'(LANE32_W - 1);

  logic sat16;
  logic sat32;
  logic [7:0] low_byte;

  always_comb begin
    low_byte = cnt[7:0];
    cnt_nz   = |cnt;
    sat16    = cnt > MAX16;
    sat32    = cnt > MAX32;
    // A saturated count shifts by lane width minus one, which fills the lane with its sign.
    amt16    = sat16 ? SH16_W'(LANE16_W - 1) : low_byte[SH16_W-1:0];
    amt32    = sat32 ? SH32_W'(LANE32_W - 1) : low_byte[SH32_W-1:0];
  end
endmodule

// File: rtl/sar_lane_shift.sv
module sar_lane_shift #(
  parameter int unsigned LANE_W = 16,
  localparam int unsigned SH_W  = $clog2(LANE_W)
) (
  input  logic [LANE_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  output logic [LANE_W-1:0] dout
);
  always_comb begin
    dout = $signed(din) >>> amt;
  end
endmodule

// File: rtl/vec_sar_unit.sv
module vec_sar_unit
  import sar_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             lane_sel,
  input  logic             wide_sel,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] cnt_opnd,
  output logic [VEC_W-1:0] res_vec,
  output logic             res_wen
);
  localparam int unsigned N16    = VEC_W / LANE16_W;
  localparam int unsigned N32    = VEC_W / LANE32_W;
  localparam int unsigned HALF_W = VEC_W / 2;

  logic              cnt_nz;
  logic [SH16_W-1:0] amt16;
  logic [SH32_W-1:0] amt32;
  logic [VEC_W-1:0]  sh16_vec;
  logic [VEC_W-1:0]  sh32_vec;
  logic [VEC_W-1:0]  vec_nxt;
  logic              wen_nxt;
  logic              unused_cnt_hi;

  assign unused_cnt_hi = ^cnt_opnd[VEC_W-1:CNT_W];

  sar_count_dec #(.CNT_W(CNT_W)) u_dec (
    .cnt    (cnt_opnd[CNT_W-1:0]),
    .cnt_nz (cnt_nz),
    .amt16  (amt16),
    .amt32  (amt32)
  );

  for (genvar g = 0; g < N16; g++) begin : g_l16
    sar_lane_shift #(.LANE_W(LANE16_W)) u_sh (
      .din  (src_vec[g*LANE16_W +: LANE16_W]),
      .amt  (amt16),
      .dout (sh16_vec[g*LANE16_W +: LANE16_W])
    );
  end

  for (genvar g = 0; g < N32; g++) begin : g_l32
    sar_lane_shift #(.LANE_W(LANE32_W)) u_sh (
      .din  (src_vec[g*LANE32_W +: LANE32_W]),
      .amt  (amt32),
      .dout (sh32_vec[g*LANE32_W +: LANE32_W])
    );
  end

  always_comb begin
    vec_nxt = (lane_e'(lane_sel) == LANE_WORD) ? sh32_vec : sh16_vec;
    if (!wide_sel) begin
      vec_nxt[VEC_W-1:HALF_W] = '0;
    end
    wen_nxt = in_valid && cnt_nz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vec <= '0;
      res_wen <= 1'b0;
    end else begin
      res_wen <= wen_nxt;
      if (in_valid) begin
        res_vec <= vec_nxt;
      end
    end
  end
endmodule

// File: rtl/vec_sar_chk.sv
module vec_sar_chk #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             lane_sel,
  input logic             wide_sel,
  input logic [VEC_W-1:0] src_vec,
  input logic [VEC_W-1:0] cnt_opnd,
  input logic [VEC_W-1:0] res_vec,
  input logic             res_wen
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (!res_wen && res_vec == '0));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_wen && $stable(res_vec)));

  a_r2_write_next: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_opnd[CNT_W-1:0] != '0) |=> res_wen);

  a_r3_zero_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_opnd[CNT_W-1:0] == '0) |=> !res_wen);

  a_r5_sat16_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lane_sel && cnt_opnd[CNT_W-1:0] > 15)
    |=> res_vec[15:0] == {16{$past(src_vec[15])}});

  a_r7_sat32_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel && cnt_opnd[CNT_W-1:0] > 31)
    |=> res_vec[31:0] == {32{$past(src_vec[31])}});

  a_r10_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_sel) |=> res_vec[VEC_W-1:VEC_W/2] == '0);
endmodule

bind vec_sar_unit vec_sar_chk #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .lane_sel (lane_sel),
  .wide_sel (wide_sel),
  .src_vec  (src_vec),
  .cnt_opnd (cnt_opnd),
  .res_vec  (res_vec),
  .res_wen  (res_wen)
);

// File: tb/vec_sar_unit_tb.sv
`timescale 1ns/1ps
module vec_sar_unit_tb;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         lane_sel;
  logic         wide_sel;
  logic [127:0] src_vec;
  logic [127:0] cnt_opnd;
  logic [127:0] res_vec;
  logic         res_wen;
  int checks = 0;
  int errors = 0;
  logic [127:0] last_vec;

  vec_sar_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_sel(lane_sel),
    .wide_sel(wide_sel), .src_vec(src_vec), .cnt_opnd(cnt_opnd),
    .res_vec(res_vec), .res_wen(res_wen)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [127:0] model_vec(input logic ls, input logic ws,
                                             input logic [127:0] v, input logic [127:0] c);
    logic [127:0] r;
    logic [63:0]  c64;
    int           lw;
    int           nl;
    int           sh;
    c64 = c[63:0];
    lw  = ls ? 32 : 16;
    nl  = (ws ? 128 : 64) / lw;
    r   = '0;
    if (c64 > 64'(lw - 1)) sh = lw;
    else sh = int'(c64[7:0]);
    for (int l = 0; l < nl; l++) begin
      for (int b = 0; b < lw; b++) begin
        if (b + sh >= lw) r[l*lw + b] = v[l*lw + lw - 1];
        else r[l*lw + b] = v[l*lw + b + sh];
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic ls, input logic ws,
                        input logic [127:0] v, input logic [127:0] c);
    @(negedge clk);
    in_valid = 1'b1; lane_sel = ls; wide_sel = ws; src_vec = v; cnt_opnd = c;
    @(negedge clk);
    in_valid = 1'b0;
    src_vec  = ~v;
    cnt_opnd = 128'h1;
    chk({req, " res_vec"}, res_vec, model_vec(ls, ws, v, c));
    chk({req, " res_wen"}, {127'd0, res_wen}, {127'd0, c[63:0] != 64'd0});
    last_vec = res_vec;
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R2 idle wen", {127'd0, res_wen}, 128'd0);
    chk("R2 idle hold", res_vec, last_vec);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] v;
    logic [127:0] c;
    void'($urandom(32'd2718));
    rst_n = 1'b0; in_valid = 1'b0; lane_sel = 1'b0; wide_sel = 1'b0;
    src_vec = '0; cnt_opnd = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset vec", res_vec, 128'd0);
    chk("R1 reset wen", {127'd0, res_wen}, 128'd0);
    rst_n = 1'b1;

    v = 128'h8001_7FFF_F0F0_1234_8000_0001_FFFF_4321;
    run_op("R4 half shift 4", 1'b0, 1'b1, v, 128'd4);
    idle_chk();
    run_op("R5 half sat 16", 1'b0, 1'b1, v, 128'd16);
    run_op("R5 half sat huge", 1'b0, 1'b1, v, 128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF);
    run_op("R6 word shift 31", 1'b1, 1'b1, v, 128'd31);
    run_op("R7 word sat 32", 1'b1, 1'b1, v, 128'd32);
    run_op("R8 high count bits saturate", 1'b0, 1'b1, v, 128'h1_0000_0003);
    run_op("R8 word high bits saturate", 1'b1, 1'b1, v, 128'h8000_0000_0000_0001);
    run_op("R3 zero count", 1'b0, 1'b1, v, 128'd0);
    idle_chk();
    run_op("R9 upper count ignored zero", 1'b1, 1'b1, v, 128'hDEAD_BEEF_0000_0001_0000_0000_0000_0000);
    run_op("R9 upper count ignored shift", 1'b0, 1'b1, v, 128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0005);
    run_op("R10 narrow half", 1'b0, 1'b0, v, 128'd3);
    run_op("R10 narrow word sat", 1'b1, 1'b0, v, 128'd40);

    for (int i = 0; i < 400; i++) begin
      v = {$urandom, $urandom, $urandom, $urandom};
      case ($urandom % 4)
        0: c = '0;
        1: c = 128'($urandom % 33);
        2: c = {64'd0, $urandom, $urandom};
        default: c = {$urandom, $urandom, 64'd0};
      endcase
      run_op("R4 R6 R10 random", 1'($urandom), 1'($urandom), v, c);
      if ((i % 16) == 0) idle_chk();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule